// File: doc/BRIEF.md
# Staged Serial Control Register for a CCD Timing Core

This block takes a 19-bit control word from a three-wire serial port (shift clock, data, strobe) and passes its fields to the rest of a CCD timing generator. All three serial wires are asynchronous to the system clock. They are brought into the clock domain, and their rising edges are detected there. Each detected shift-clock edge moves one data bit into a shift register. A detected strobe edge copies the whole shift register into a holding register.

The four 2-bit pulse-phase selects go to the pulse-phase logic one cycle after the holding register is written. The electronic-shutter fields are handled differently. They are never applied at the strobe. The 2-bit shutter mode is committed at the first readout-active line start after the strobe. The 9-bit shutter speed is committed at the next readout-active line start after that one. A new strobe before this sequence ends starts it again from the mode step, using the newest holding contents. The timing core supplies a one-cycle line-start pulse and a level that marks a readout-active line.

Top module: `ccd_serial_ctrl`

## Requirements
- R1: While reset is low, and after it is released with no serial traffic, every output reads zero.
- R2: The first bit shifted in becomes word bit 0 (D00), and the nineteenth becomes bit 18 (D18). Data is taken at each rising edge of the serial shift clock.
- R3: The phase-select outputs change only after a strobe rising edge. They hold their value at every other time.
- R4: The phase fields are taken from fixed word positions: reset select from bits 12:11, CDS select from 14:13, sample-hold select from 16:15 and feed-through select from 18:17.
- R5: A strobe does not change the shutter mode or shutter speed outputs.
- R6: The shutter mode (word bits 10:9) is committed at the first line start with readout_line high after the strobe. Line starts with readout_line low are ignored.
- R7: The shutter speed (word bits 8:0) is committed at the next readout-active line start after the mode commit. Mode and speed never change at the same line start.
- R8: A strobe that arrives while a transfer is pending restarts it at the mode step, and the newest holding contents are transferred.
- R9: With no transfer pending, readout-active line starts leave the shutter outputs unchanged.
- R10: Shifting bits without a strobe changes no output. A later strobe alone latches the bits that were shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_strobe | input | 1 | Serial latch strobe, asynchronous |
| line_start | input | 1 | One-cycle pulse at the start of each horizontal line |
| readout_line | input | 1 | High during a line in which the readout pulse is active |
| shut_speed | output | 9 | Committed electronic-shutter speed |
| shut_mode | output | 2 | Committed electronic-shutter mode |
| ph_rst_sel | output | 2 | Phase select for the reset pulse |
| ph_cds_sel | output | 2 | Phase select for the CDS pulse |
| ph_sh_sel | output | 2 | Phase select for the sample-hold pulse |
| ph_ft_sel | output | 2 | Phase select for the feed-through pulse |

## Verification
The hardest case to reach from the ports is a second strobe that lands between the mode commit and the speed commit. The pending transfer must then drop the old speed and restart with the new word. The stimulus commits a mode, loads a new word over the serial port, and then drives two more readout-active line starts. A design that does not restart would apply the stale speed at the first of those two lines.

A second hard case is a word that is shifted in but not strobed. Readout-active lines are driven while those bits sit only in the shift register, and the outputs are checked to show nothing moved. A strobe alone then follows, and its contents are checked.

// File: rtl/ccd_serial_pkg.sv
// Shared constants and types for the staged serial control register.
package ccd_serial_pkg;
    localparam int NUM_PHASE   = 4;   // reset, CDS, sample-hold, feed-through
    localparam int DEF_SPEED_W = 9;
    localparam int DEF_MODE_W  = 2;
    localparam int DEF_PHASE_W = 2;

    // Progress of a staged shutter transfer
    typedef enum logic [1:0] {
        CM_IDLE       = 2'd0,
        CM_WAIT_MODE  = 2'd1,
        CM_WAIT_SPEED = 2'd2
    } commit_state_e;
endpackage

// File: rtl/sctl_sync.sv
// Multi-bit synchroniser: each bit passes through STAGES flops.
// Assumes the inputs are slow relative to clk, so that each bit is
// synchronised on its own without loss.
module sctl_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    logic [N-1:0] pipe [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[0] <= '0;
                    else        pipe[0] <= async_in;
                end
            end else begin : g_next
                // shift through the following stages
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[s] <= '0;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = pipe[STAGES-1];
endmodule

// File: rtl/sctl_rise.sv
// Rising-edge detector: compares each synchronised bit with its value
// in the previous cycle. Assumes the inputs are already in the clk domain.
module sctl_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    // keep the previous sample
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/sctl_word_latch.sv
// Serial shift register and holding register. Each shift_en moves din into
// the top bit, so after WORD_W shifts the first bit sits in bit 0. A load
// pulse copies the shift register into the holding register, and hold_new
// flags the following cycle. Assumes shift_en and load are single-cycle.
module sctl_word_latch #(
    parameter int WORD_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic              load,
    output logic [WORD_W-1:0] hold_word,
    output logic              hold_new
);
    logic [WORD_W-1:0] shift_q;

    // shift one bit per detected serial clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (shift_en) shift_q <= {din, shift_q[WORD_W-1:1]};
    end

    // copy the shift register on a detected strobe edge
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_word <= '0;
        else if (load) hold_word <= shift_q;
    end

    // flag that the holding register has just been written
    always_ff @(posedge clk) begin
        if (!rst_n) hold_new <= 1'b0;
        else        hold_new <= load;
    end
endmodule

// File: rtl/sctl_phase_regs.sv
// Active phase-select registers. All fields are updated together in the
// cycle after the holding register is written. Assumes hold_new is a
// single-cycle pulse.
module sctl_phase_regs #(
    parameter int PHASE_W   = 2,
    parameter int NUM_PHASE = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hold_new,
    input  logic [NUM_PHASE*PHASE_W-1:0]  fields_in,
    output logic [NUM_PHASE*PHASE_W-1:0]  fields_out
);
    genvar f;
    generate
        for (f = 0; f < NUM_PHASE; f++) begin : g_field
            // load one phase field from the holding register
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fields_out[f*PHASE_W +: PHASE_W] <= '0;
                else if (hold_new)
                    fields_out[f*PHASE_W +: PHASE_W] <= fields_in[f*PHASE_W +: PHASE_W];
            end
        end
    endgenerate
endmodule

// File: rtl/sctl_shutter_commit.sv
// Two-step, line-aligned transfer of the shutter fields. A holding-register
// write arms the transfer, or re-arms it if one is already pending. The
// first readout-active line start then commits the mode, and the next one
// commits the speed. A re-arm takes priority over a line start in the same
// cycle. Assumes line_start is a single-cycle pulse in the clk domain.
module sctl_shutter_commit #(
    parameter int SPEED_W = 9,
    parameter int MODE_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold_new,
    input  logic [SPEED_W-1:0] hold_speed,
    input  logic [MODE_W-1:0]  hold_mode,
    input  logic               line_start,
    input  logic               readout_line,
    output logic [SPEED_W-1:0] speed_q,
    output logic [MODE_W-1:0]  mode_q
);
    import ccd_serial_pkg::*;

    commit_state_e state_q, state_d;
    logic          ro_boundary;
    logic          take_mode;
    logic          take_speed;

    assign ro_boundary = line_start & readout_line;

    // decide the next transfer step
    always_comb begin
        state_d    = state_q;
        take_mode  = 1'b0;
        take_speed = 1'b0;
        if (hold_new) begin
            state_d = CM_WAIT_MODE;
        end else if (ro_boundary) begin
            case (state_q)
                CM_WAIT_MODE: begin
                    take_mode = 1'b1;
                    state_d   = CM_WAIT_SPEED;
                end
                CM_WAIT_SPEED: begin
                    take_speed = 1'b1;
                    state_d    = CM_IDLE;
                end
                default: state_d = CM_IDLE;
            endcase
        end
    end

    // hold the transfer step
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CM_IDLE;
        else        state_q <= state_d;
    end

    // commit the mode field
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= '0;
        else if (take_mode) mode_q <= hold_mode;
    end

    // commit the speed field
    always_ff @(posedge clk) begin
        if (!rst_n)          speed_q <= '0;
        else if (take_speed) speed_q <= hold_speed;
    end
endmodule

// File: rtl/ccd_serial_ctrl.sv
// Top of the staged serial control register. It synchronises the serial
// wires, shifts and latches the control word, sends the phase fields to
// their registers, and sends the shutter fields through the line-aligned
// commit stage. Word layout: speed at the bottom, then mode, then the four
// phase fields (reset, CDS, sample-hold, feed-through). Assumes line_start
// and readout_line are already synchronous to clk.
module ccd_serial_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int SPEED_W     = ccd_serial_pkg::DEF_SPEED_W,
    parameter int MODE_W      = ccd_serial_pkg::DEF_MODE_W,
    parameter int PHASE_W     = ccd_serial_pkg::DEF_PHASE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_strobe,
    input  logic               line_start,
    input  logic               readout_line,
    output logic [SPEED_W-1:0] shut_speed,
    output logic [MODE_W-1:0]  shut_mode,
    output logic [PHASE_W-1:0] ph_rst_sel,
    output logic [PHASE_W-1:0] ph_cds_sel,
    output logic [PHASE_W-1:0] ph_sh_sel,
    output logic [PHASE_W-1:0] ph_ft_sel
);
    import ccd_serial_pkg::*;

    localparam int PH_ALL_W  = NUM_PHASE * PHASE_W;
    localparam int MODE_LSB  = SPEED_W;
    localparam int PH_LSB    = SPEED_W + MODE_W;
    localparam int WORD_W    = PH_LSB + PH_ALL_W;

    logic [2:0]          sync_lvl;   // {strobe, data, clock}
    logic [1:0]          edge_rise;  // {strobe, clock}
    logic [WORD_W-1:0]   hold_word;
    logic                hold_new;
    logic [PH_ALL_W-1:0] ph_all;

    sctl_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_strobe, ser_data, ser_clk}),
        .sync_out (sync_lvl)
    );

    sctl_rise #(.N(2)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({sync_lvl[2], sync_lvl[0]}),
        .rise  (edge_rise)
    );

    sctl_word_latch #(.WORD_W(WORD_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (edge_rise[0]),
        .din       (sync_lvl[1]),
        .load      (edge_rise[1]),
        .hold_word (hold_word),
        .hold_new  (hold_new)
    );

    sctl_phase_regs #(.PHASE_W(PHASE_W), .NUM_PHASE(NUM_PHASE)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_new   (hold_new),
        .fields_in  (hold_word[PH_LSB +: PH_ALL_W]),
        .fields_out (ph_all)
    );

    sctl_shutter_commit #(.SPEED_W(SPEED_W), .MODE_W(MODE_W)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_new     (hold_new),
        .hold_speed   (hold_word[0 +: SPEED_W]),
        .hold_mode    (hold_word[MODE_LSB +: MODE_W]),
        .line_start   (line_start),
        .readout_line (readout_line),
        .speed_q      (shut_speed),
        .mode_q       (shut_mode)
    );

    assign ph_rst_sel = ph_all[0*PHASE_W +: PHASE_W];
    assign ph_cds_sel = ph_all[1*PHASE_W +: PHASE_W];
    assign ph_sh_sel  = ph_all[2*PHASE_W +: PHASE_W];
    assign ph_ft_sel  = ph_all[3*PHASE_W +: PHASE_W];
endmodule

// File: rtl/ccd_serial_ctrl_chk.sv
// Checker for the staged serial control register, bound to the top module.
// It relates output changes to the latch pulse and to line boundaries.
module ccd_serial_ctrl_chk #(
    parameter int SPEED_W = 9,
    parameter int MODE_W  = 2,
    parameter int PH_W    = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_start,
    input logic               readout_line,
    input logic               hold_new,
    input logic [SPEED_W-1:0] shut_speed,
    input logic [MODE_W-1:0]  shut_mode,
    input logic [PH_W-1:0]    phases
);
    // R3: phase selects move only right after a holding-register write
    p_phase_on_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phases != $past(phases)) |-> $past(hold_new));

    // R5: the cycle that follows a latch leaves the shutter outputs alone
    p_quiet_on_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_new |=> ($stable(shut_mode) && $stable(shut_speed)));

    // R6: mode moves only at a readout-active line start
    p_mode_at_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_mode != $past(shut_mode)) |-> $past(line_start && readout_line));

    // R7: speed moves only at a readout-active line start
    p_speed_at_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_speed != $past(shut_speed)) |-> $past(line_start && readout_line));

    // R7: mode and speed never commit at the same boundary
    p_one_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !((shut_mode != $past(shut_mode)) && (shut_speed != $past(shut_speed))));
endmodule

bind ccd_serial_ctrl ccd_serial_ctrl_chk #(
    .SPEED_W (SPEED_W),
    .MODE_W  (MODE_W),
    .PH_W    (4*PHASE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start   (line_start),
    .readout_line (readout_line),
    .hold_new     (hold_new),
    .shut_speed   (shut_speed),
    .shut_mode    (shut_mode),
    .phases       ({ph_ft_sel, ph_sh_sel, ph_cds_sel, ph_rst_sel})
);

// File: tb/ccd_serial_ctrl_bench.sv
// Scoreboard bench: driver tasks update a model and queue the expected
// output snapshot. A monitor pops an item every time the outputs change.
module ccd_serial_ctrl_bench;
    localparam int CLK_P = 10;
    localparam int W     = 19;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_strobe = 1'b0;
    logic line_start = 1'b0, readout_line = 1'b0;
    logic [8:0] shut_speed;
    logic [1:0] shut_mode, ph_rst_sel, ph_cds_sel, ph_sh_sel, ph_ft_sel;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    // model state
    logic [W-1:0] m_shift = '0, m_hold = '0, m_last = '0;
    logic [7:0]   m_ph = '0;
    logic [1:0]   m_mode = '0;
    logic [8:0]   m_speed = '0;
    int           m_pend = 0;
    logic [W-1:0] mon_prev = '0;

    always #(CLK_P/2) clk = ~clk;

    ccd_serial_ctrl u_ccd_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_strobe(ser_strobe), .line_start(line_start), .readout_line(readout_line),
        .shut_speed(shut_speed), .shut_mode(shut_mode), .ph_rst_sel(ph_rst_sel),
        .ph_cds_sel(ph_cds_sel), .ph_sh_sel(ph_sh_sel), .ph_ft_sel(ph_ft_sel)
    );

    function automatic logic [W-1:0] port_snap();
        return {ph_ft_sel, ph_sh_sel, ph_cds_sel, ph_rst_sel, shut_mode, shut_speed};
    endfunction

    function automatic logic [W-1:0] model_snap();
        return {m_ph, m_mode, m_speed};
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_if(string tag);
        exp_t it;
        if (model_snap() != m_last) begin
            it.val = model_snap();
            it.tag = tag;
            q.push_back(it);
            m_last = model_snap();
        end
    endtask

    // monitor: every output change must match the next queued item
    always @(negedge clk) begin
        if (rst_n && port_snap() != mon_prev) begin
            if (q.size() == 0) begin
                check("unexpected change", port_snap(), mon_prev);
            end else begin
                exp_t it;
                it = q.pop_front();
                check(it.tag, port_snap(), it.val);
            end
            mon_prev = port_snap();
        end
    end

    task automatic shift_bits(logic [W-1:0] word);
        for (int k = 0; k < W; k++) begin
            ser_data = word[k];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            m_shift = {word[k], m_shift[W-1:1]};
        end
    endtask

    task automatic strobe(string tag);
        m_hold = m_shift;
        m_ph   = m_hold[18:11];
        m_pend = 1;
        push_if(tag);
        ser_strobe = 1'b1;
        repeat (4) @(negedge clk);
        ser_strobe = 1'b0;
        repeat (8) @(negedge clk);
        // R5: the shutter outputs are untouched by the strobe
        check("R5 shutter unchanged at strobe", {10'd0, shut_mode, shut_speed},
              {10'd0, m_mode, m_speed});
    endtask

    task automatic line(logic ro, string tag);
        if (ro && m_pend == 1) begin
            m_mode = m_hold[10:9];
            m_pend = 2;
        end else if (ro && m_pend == 2) begin
            m_speed = m_hold[8:0];
            m_pend  = 0;
        end
        push_if(tag);
        line_start   = 1'b1;
        readout_line = ro;
        @(negedge clk);
        line_start   = 1'b0;
        readout_line = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [W-1:0] wa, wb, wc, wd;
        wa = {2'd0, 2'd3, 2'd2, 2'd1, 2'd2, 9'h1A5};
        wb = {2'd1, 2'd0, 2'd3, 2'd2, 2'd1, 9'h05A};
        wc = {2'd2, 2'd2, 2'd1, 2'd1, 2'd3, 9'h0FF};
        wd = 19'h40001;   // only D18 and D00 set

        repeat (3) @(negedge clk);
        check("R1 reset held", port_snap(), '0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 after release", port_snap(), '0);

        // R2 R4: word A, phase fields then staged shutter fields
        shift_bits(wa);
        strobe("R2 R4 phases of word A");
        check("R3 phases A", port_snap(), model_snap());
        line(1'b0, "R6 non-readout ignored");
        line(1'b0, "R6 non-readout ignored");
        check("R6 nothing before readout line", port_snap(), model_snap());
        line(1'b1, "R6 mode of word A");
        line(1'b0, "R7 non-readout ignored");
        line(1'b1, "R7 speed of word A");
        check("R7 full word A", port_snap(), wa);

        // R9: idle readout lines change nothing
        line(1'b1, "R9 idle");
        line(1'b1, "R9 idle");
        check("R9 idle lines", port_snap(), wa);

        // R10: shifting without a strobe changes nothing
        shift_bits(wb);
        line(1'b1, "R10 no strobe");
        line(1'b1, "R10 no strobe");
        check("R10 shift without strobe", port_snap(), wa);
        strobe("R10 strobe alone latches B");
        line(1'b1, "R6 mode of word B");
        line(1'b1, "R7 speed of word B");
        check("R10 full word B", port_snap(), wb);

        // R8: new strobe between mode and speed commits
        shift_bits(wc);
        strobe("R3 phases of word C");
        line(1'b1, "R6 mode of word C");
        shift_bits(wd);
        strobe("R8 R2 phases of word D");
        line(1'b1, "R8 restart mode of word D");
        check("R8 speed kept after restart", {10'd0, shut_speed}, {10'd0, wb[8:0]});
        line(1'b1, "R8 R2 speed of word D");
        check("R8 full word D", port_snap(), wd);

        repeat (10) @(negedge clk);
        check("R6 R7 queue drained", W'(q.size()), '0);
        finish_run();
    end
endmodule